// File: doc/BRIEF.md
# Address-Gated Two-Wire Bus Slave

This block is the serial front end of a small bus-controlled peripheral. It watches a two-wire bus (clock line and open-drain data line) with a fast system clock and recognises the start and stop framing conditions. It checks a 7-bit device address bit by bit against a fixed six-bit prefix and one pin-selected low bit. A register block sits behind it. Bytes written by the master are handed to that block with a one-cycle strobe. On a read, the 16-bit word the register block presents is shifted back to the master as two bytes.

The address is checked as each bit arrives. On the first bit that differs, the slave drops to an idle state in which clock edges are ignored until a new start condition. A stop condition leads to the same idle state. The data line is never driven high: the only output toward the bus is a pull-down enable.

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset the pull-down enable is low, `selected_o` is low and no write strobe is issued.
- R2: A falling data line while the clock is high (start) sets `selected_o`. A rising data line while the clock is high (stop) clears it.
- R3: The address is sent most significant bit first. Bits 6..1 must equal the `PREFIX` parameter (default 6'b001000), and bit 0 must equal `addr_lsb`. A matching address is acknowledged by pulling the data line low during the ninth clock.
- R4: The first address bit that differs ends the transfer: there is no acknowledge, `selected_o` falls, and later bytes are neither acknowledged nor strobed until the next start.
- R5: The all-zero address is never acknowledged.
- R6: In a write, each received byte (most significant bit first) is acknowledged. `wr_byte_o` is presented with a one-cycle `wr_stb_o` at the falling clock edge that ends the acknowledge clock. `wr_first_o` is 1 only for the first byte after the address.
- R7: A repeated start inside a write starts a new address phase without a stop. The first byte after it again carries `wr_first_o` = 1.
- R8: A read address (R/W bit = 1) is acknowledged only after a repeated start. After a start that follows a stop or reset, it is treated as a mismatch.
- R9: A read sends `rd_word[15:8]` and then `rd_word[7:0]`, most significant bit first, with the pull-down enabled exactly for 0 bits. The master's acknowledge is sampled after each byte. A not-acknowledge releases the line and returns the slave to idle.
- R10: A stop in the same clock-high phase as the preceding start is ignored, and the address that follows is still processed. A stop anywhere else, even mid-byte, returns to idle and strobes no partial byte.
- R11: The pull-down enable only changes while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| addr_lsb | input | 1 | Address bit 0 select |
| rd_word | input | 16 | Word returned on reads, high byte first |
| sda_pull_o | output | 1 | Data-line pull-down enable (1 = drive low) |
| selected_o | output | 1 | High while the slave follows the bus clock |
| wr_byte_o | output | 8 | Last received write byte |
| wr_first_o | output | 1 | Received byte was the first after the address |
| wr_stb_o | output | 1 | One-cycle strobe for `wr_byte_o` |

## Verification
Start and stop detection can both fire inside one clock-high phase. The bench provokes this by lowering and then raising the data line before the clock falls. The ignored stop is judged by whether the following address is still acknowledged and its byte strobed. A second collision is a stop that arrives in the middle of a byte, right after a clock rise has shifted in a bit. That case passes if `selected_o` falls and no write strobe appears for the partial byte.

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave #(
  parameter logic [5:0] PREFIX = 6'b001000,
  parameter int SYNC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        addr_lsb,
  input  logic [15:0] rd_word,
  output logic        sda_pull_o,
  output logic        selected_o,
  output logic [7:0]  wr_byte_o,
  output logic        wr_first_o,
  output logic        wr_stb_o
);
  typedef enum logic [2:0] {IDLE, ADDR, AACK, RX, RACK, TX, TACK} st_t;

  logic [SYNC-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q;
  wire scl_s = scl_sr[SYNC-1];
  wire sda_s = sda_sr[SYNC-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sr <= '1; sda_sr <= '1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  st_t state;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic nz, rw, rep, busy, start_hi, first, lo_next;
  wire [6:0] my_addr = {PREFIX, addr_lsb};
  wire exp_bit = my_addr[3'd6 - cnt[2:0]];

  assign selected_o = (state != IDLE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= IDLE; cnt <= '0; shreg <= '0; nz <= 1'b0; rw <= 1'b0;
      rep <= 1'b0; busy <= 1'b0; start_hi <= 1'b0; first <= 1'b0;
      lo_next <= 1'b0; sda_pull_o <= 1'b0; wr_byte_o <= '0;
      wr_first_o <= 1'b0; wr_stb_o <= 1'b0;
    end else begin
      wr_stb_o <= 1'b0;
      if (scl_fall) start_hi <= 1'b0;
      if (start_c) begin
        state <= ADDR; cnt <= '0; nz <= 1'b0; sda_pull_o <= 1'b0;
        rep <= busy; busy <= 1'b1; start_hi <= 1'b1;
      end else if (stop_c && !start_hi) begin
        state <= IDLE; sda_pull_o <= 1'b0; busy <= 1'b0;
      end else begin
        case (state)
          ADDR: begin
            if (scl_rise) begin
              if (cnt < 4'd7) begin
                if (sda_s != exp_bit || (cnt == 4'd6 && !nz && !sda_s))
                  state <= IDLE;
                nz  <= nz | sda_s;
                cnt <= cnt + 4'd1;
              end else if (cnt == 4'd7) begin
                if (sda_s && !rep) state <= IDLE;
                rw  <= sda_s;
                cnt <= 4'd8;
              end
            end else if (scl_fall && cnt == 4'd8) begin
              sda_pull_o <= 1'b1;
              state <= AACK;
            end
          end
          AACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              shreg <= rd_word[15:8];
              sda_pull_o <= ~rd_word[15];
              lo_next <= 1'b1;
              state <= TX;
            end else begin
              sda_pull_o <= 1'b0;
              first <= 1'b1;
              state <= RX;
            end
          end
          RX: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              sda_pull_o <= 1'b1;
              state <= RACK;
            end
          end
          RACK: if (scl_fall) begin
            sda_pull_o <= 1'b0;
            wr_stb_o <= 1'b1;
            wr_byte_o <= shreg;
            wr_first_o <= first;
            first <= 1'b0;
            cnt <= '0;
            state <= RX;
          end
          TX: if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_pull_o <= 1'b0;
              state <= TACK;
            end else begin
              shreg <= {shreg[6:0], 1'b0};
              sda_pull_o <= ~shreg[6];
              cnt <= cnt + 4'd1;
            end
          end
          TACK: begin
            if (scl_rise && sda_s) state <= IDLE;
            else if (scl_fall) begin
              shreg <= lo_next ? rd_word[7:0] : rd_word[15:8];
              sda_pull_o <= lo_next ? ~rd_word[7] : ~rd_word[15];
              lo_next <= ~lo_next;
              cnt <= '0;
              state <= TX;
            end
          end
          default: ;
        endcase
      end
    end

  a_r11_pull_rises_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> $past(scl_fall));
  a_r6_stb_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);
  a_r6_stb_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> $past(scl_fall));
  a_r4_idle_until_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state == IDLE && !start_c) |=> state == IDLE);
  a_r2_stop_deselects: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_c && !start_hi) |=> !selected_o);
  a_r9_idle_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !selected_o |-> !sda_pull_o);
endmodule

// File: tb/i2c_addr_slave_bench.sv
module i2c_addr_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] RDW = 16'hC35A;
  localparam logic [15:0] VEC [7] = '{
    {7'h10, 8'hA5, 1'b1}, {7'h11, 8'h3C, 1'b0}, {7'h50, 8'h10, 1'b0},
    {7'h00, 8'h55, 1'b0}, {7'h10, 8'h00, 1'b1}, {7'h10, 8'hFF, 1'b1},
    {7'h18, 8'h81, 1'b0}};

  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1, addr_lsb = 0;
  logic pull, sel, first, stb;
  logic [7:0] wbyte;
  wire sda_bus = sda_m & ~pull;

  i2c_addr_slave u_i2c_addr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .addr_lsb(addr_lsb),
    .rd_word(RDW), .sda_pull_o(pull), .selected_o(sel), .wr_byte_o(wbyte),
    .wr_first_o(first), .wr_stb_o(stb));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, stb_cnt = 0, first_cnt = 0, viol = 0;
  logic [7:0] last_byte = 0;
  logic last_first = 0, prev_pull = 0;

  always @(negedge clk) begin
    if (rst_n && stb) begin
      stb_cnt++; last_byte = wbyte; last_first = first;
      if (first) first_cnt++;
    end
    if (rst_n && pull !== prev_pull && scl) viol++;
    prev_pull = pull;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask
  task automatic bitx(input logic b, output logic s);
    sda_m = b; w(4); scl = 1; w(4); s = sda_bus; w(4); scl = 0; w(4);
  endtask
  task automatic start_c; sda_m = 1; w(4); scl = 1; w(8); sda_m = 0; w(8); scl = 0; w(4); endtask
  task automatic stop_c; sda_m = 0; w(4); scl = 1; w(8); sda_m = 1; w(8); endtask
  task automatic wbyte_t(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bitx(b[i], s);
    bitx(1'b1, s); ack = ~s;
  endtask
  task automatic rbyte_t(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin bitx(1'b1, s); d[i] = s; end
    bitx(~mack, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int c0, f0;
    w(5); rst_n = 1; w(5);
    check(pull == 0 && sel == 0 && stb_cnt == 0, "R1 reset", {pull, sel}, 0);

    for (int i = 0; i < 7; i++) begin
      c0 = stb_cnt;
      start_c();
      check(sel == 1, "R2 start selects", sel, 1);
      wbyte_t({VEC[i][15:9], 1'b0}, ack);
      check(ack == VEC[i][0], "R3/R4/R5 address ack", ack, VEC[i][0]);
      wbyte_t(VEC[i][8:1], ack);
      check(ack == VEC[i][0], "R6 data ack", ack, VEC[i][0]);
      check(stb_cnt - c0 == int'(VEC[i][0]), "R6 strobe count", stb_cnt - c0, VEC[i][0]);
      if (VEC[i][0])
        check(last_byte == VEC[i][8:1] && last_first, "R6 byte/first", last_byte, VEC[i][8:1]);
      stop_c();
      check(sel == 0, "R2 stop deselects", sel, 0);
    end

    addr_lsb = 1;
    start_c(); wbyte_t(8'h22, ack); stop_c();
    check(ack == 1, "R3 lsb pin high match", ack, 1);
    start_c(); wbyte_t(8'h20, ack); stop_c();
    check(ack == 0, "R3 lsb pin high mismatch", ack, 0);
    addr_lsb = 0;

    c0 = stb_cnt;
    start_c(); wbyte_t(8'hA0, ack); wbyte_t(8'h20, ack);
    check(ack == 0 && sel == 0 && stb_cnt == c0, "R4 ignored after mismatch", ack, 0);
    stop_c();

    c0 = stb_cnt; f0 = first_cnt;
    start_c(); wbyte_t(8'h20, ack);
    wbyte_t(8'h11, ack); wbyte_t(8'h22, ack); wbyte_t(8'h33, ack);
    check(stb_cnt - c0 == 3 && last_byte == 8'h33, "R6 multi-byte", last_byte, 8'h33);
    check(first_cnt - f0 == 1 && !last_first, "R6 first flag once", first_cnt - f0, 1);
    start_c(); wbyte_t(8'h20, ack); wbyte_t(8'h44, ack);
    check(ack && last_byte == 8'h44 && last_first, "R7 repeated start write", last_byte, 8'h44);
    stop_c();

    start_c(); wbyte_t(8'h21, ack);
    check(ack == 0 && sel == 0, "R8 read without repeated start", ack, 0);
    stop_c();

    start_c(); wbyte_t(8'h20, ack); wbyte_t(8'h80, ack);
    start_c(); wbyte_t(8'h21, ack);
    check(ack == 1, "R8 read after repeated start", ack, 1);
    rbyte_t(1'b1, d);
    check(d == RDW[15:8], "R9 read high byte", d, RDW[15:8]);
    rbyte_t(1'b0, d);
    check(d == RDW[7:0], "R9 read low byte", d, RDW[7:0]);
    w(4);
    check(sel == 0 && pull == 0, "R9 nack releases", {sel, pull}, 0);
    stop_c();

    c0 = stb_cnt;
    sda_m = 1; w(4); scl = 1; w(8); sda_m = 0; w(4); sda_m = 1; w(4); scl = 0; w(4);
    check(sel == 1, "R10 same-phase stop ignored", sel, 1);
    wbyte_t(8'h20, ack); wbyte_t(8'h5C, ack);
    check(ack && stb_cnt == c0 + 1 && last_byte == 8'h5C, "R10 transfer continues", last_byte, 8'h5C);
    stop_c();

    c0 = stb_cnt;
    start_c(); wbyte_t(8'h20, ack);
    for (int i = 0; i < 4; i++) bitx(1'b1, ack);
    stop_c(); w(4);
    check(sel == 0 && stb_cnt == c0, "R10 mid-byte stop", stb_cnt - c0, 0);

    check(viol == 0, "R11 pull changes only with clock low", viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule